// File: doc/BRIEF.md
# ECC Error Logging Register Block

This block sits next to a single-error-correct, double-error-detect memory controller and keeps a record of the errors that controller reports. The controller gives it a one-cycle pulse for each corrected error and for each uncorrectable error. Each pulse comes with the DRAM coordinates of the access (rank, bank group, bank, row, column) and a 96-bit syndrome. The two error classes are tracked separately. Each class has a saturating 16-bit count, a sticky flag, a capture of the coordinates and syndrome of the first error seen since its flag was last cleared, and a level interrupt of its own.

Software reaches the block through a plain 32-bit register port. Reads are combinational from a byte address, and writes take effect on the clock edge where the write strobe is high. A write-one-to-clear register clears the flags and counts, one bit for each. An ECC settings register holds a scrub-disable bit and a 3-bit mode field. A read-only word reports the rank-enable mask, which comes from static input pins.

Top module: `ecc_err_log`

## Requirements
- R1: The word at 0x80 holds the corrected count in bits 15:0 and the uncorrectable count in bits 31:16. Each error pulse adds one to its class count, and the new value is visible after the clock edge that samples the pulse.
- R2: Each count saturates at 0xFFFF. Further pulses leave it at 0xFFFF.
- R3: A class captures coordinates and syndrome only when its flag is clear. The capture holds until the flag is cleared, so later errors change only the count.
  - Corrected capture: address word 0x84 and 0x88; syndrome words 0x8C, 0x90 and 0x94, holding syndrome bits 31:0, 63:32 and 95:64.
  - Uncorrectable capture: address word 0xA4 and 0xA8; syndrome words 0xAC, 0xB0 and 0xB4.
  - The first address word holds rank in bits 25:24 and row in bits 17:0.
  - The second address word holds bank group in bits 25:24, bank in bits 18:16 and column in bits 11:0.
- R4: Each class drives its own interrupt. The interrupt is high exactly when that class's flag is set and its count is nonzero, so it is low whenever the count is zero.
- R5: Writing 0x7C clears state, one bit for each action, and several bits may be set in one write. The word reads as zero.
  - Bit 0 clears the corrected flag.
  - Bit 1 clears the uncorrectable flag.
  - Bit 2 zeroes the corrected count.
  - Bit 3 zeroes the uncorrectable count.
- R6: An error pulse in the same cycle as a clear of its class wins.
  - With a count clear, the count becomes 1.
  - With a flag clear, the flag stays set and the capture takes the new error.
  - With only a count clear and the flag already set, the old capture is kept.
- R7: The word at 0x00 reports the rank-enable input in bits 27:24, and all its other bits read zero.
- R8: The word at 0x70 stores the written bit 4 (scrub disable) and bits 2:0 (mode). Its other bits read zero, and it changes only when 0x70 is written.
- R9: After reset all counts, flags, captures and settings are zero and both interrupts are low.
- R10: Writes to the configuration, count and capture words have no effect.
- R11: An error in one class changes nothing in the other class's count, capture or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_err | input | 1 | Corrected error pulse |
| ce_rank | input | 2 | Rank of corrected error |
| ce_bg | input | 2 | Bank group of corrected error |
| ce_bank | input | 3 | Bank of corrected error |
| ce_row | input | 18 | Row of corrected error |
| ce_col | input | 12 | Column of corrected error |
| ce_syn | input | 96 | Syndrome of corrected error |
| ue_err | input | 1 | Uncorrectable error pulse |
| ue_rank | input | 2 | Rank of uncorrectable error |
| ue_bg | input | 2 | Bank group of uncorrectable error |
| ue_bank | input | 3 | Bank of uncorrectable error |
| ue_row | input | 18 | Row of uncorrectable error |
| ue_col | input | 12 | Column of uncorrectable error |
| ue_syn | input | 96 | Syndrome of uncorrectable error |
| cfg_rank_en | input | 4 | Static rank-enable mask |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_ce | output | 1 | Corrected error interrupt |
| irq_ue | output | 1 | Uncorrectable error interrupt |

## Verification
The assertions check on every cycle the relations that hold between consecutive states:
- a count steps by exactly one, or holds at saturation;
- a count reads zero after a bare clear and one after a clear that loses to an error;
- a capture stays put while the flag is held;
- an interrupt stays quiet on a zero count;
- the settings register changes only when it is written.

Only the bench's scenarios can show that the register map puts each field at the right bit position and offset. The same holds for the clear bits, which are swept over all sixteen combinations. The bench also shows that the rank mask and settings patterns read back correctly, and that the same-cycle races between a clear and an error resolve as specified.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
    localparam int WORD_W    = 32;
    localparam int CNT_W     = 16;
    localparam int RANK_W    = 2;
    localparam int BG_W      = 2;
    localparam int BANK_W    = 3;
    localparam int ROW_W     = 18;
    localparam int COL_W     = 12;
    localparam int SYN_WORDS = 3;
    localparam int SYN_W     = SYN_WORDS * WORD_W;
    localparam int NCLS      = 2;   // class 0 = corrected, class 1 = uncorrectable
    localparam int RANKS     = 4;

    localparam logic [7:0] OFS_CFG    = 8'h00;
    localparam logic [7:0] OFS_ECC    = 8'h70;
    localparam logic [7:0] OFS_CLR    = 8'h7C;
    localparam logic [7:0] OFS_CNT    = 8'h80;
    localparam logic [7:0] OFS_CE_A0  = 8'h84;
    localparam logic [7:0] OFS_UE_A0  = 8'hA4;
    localparam logic [7:0] OFS_SYN_D  = 8'h08; // syndrome base minus address base
    localparam logic [WORD_W-1:0] ECC_WMASK = 32'h0000_0017;

    typedef struct packed {
        logic [RANK_W-1:0] rank;
        logic [BG_W-1:0]   bg;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } dram_loc_t;

    function automatic logic [WORD_W-1:0] loc_word0(dram_loc_t l);
        logic [WORD_W-1:0] w;
        w = '0;
        w[25:24] = l.rank;
        w[17:0]  = l.row;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] loc_word1(dram_loc_t l);
        logic [WORD_W-1:0] w;
        w = '0;
        w[25:24] = l.bg;
        w[18:16] = l.bank;
        w[11:0]  = l.col;
        return w;
    endfunction
endpackage

// File: rtl/ecc_class_tracker.sv
module ecc_class_tracker
    import ecc_log_pkg::*;
#(
    parameter int CNT_BITS = CNT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                err_i,
    input  dram_loc_t           loc_i,
    input  logic [SYN_W-1:0]    syn_i,
    input  logic                clr_flag_i,
    input  logic                clr_cnt_i,
    output logic [CNT_BITS-1:0] cnt_o,
    output dram_loc_t           loc_o,
    output logic [SYN_W-1:0]    syn_o,
    output logic                irq_o
);
    localparam logic [CNT_BITS-1:0] CNT_MAX = '1;
    localparam logic [CNT_BITS-1:0] CNT_ONE = {{(CNT_BITS-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_BITS-1:0] cnt;
        logic                flag;
        dram_loc_t           loc;
        logic [SYN_W-1:0]    syn;
    } trk_st_t;

    trk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_cnt_i)  st_d.cnt  = '0;
        if (clr_flag_i) st_d.flag = 1'b0;
        if (err_i) begin
            if (clr_cnt_i)
                st_d.cnt = CNT_ONE;
            else if (st_q.cnt != CNT_MAX)
                st_d.cnt = st_q.cnt + CNT_ONE;
            if (!st_q.flag || clr_flag_i) begin
                st_d.loc = loc_i;
                st_d.syn = syn_i;
            end
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign loc_o = st_q.loc;
    assign syn_o = st_q.syn;
    assign irq_o = st_q.flag && (st_q.cnt != '0);

    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (err_i && !clr_cnt_i && cnt_o != CNT_MAX) |=> (cnt_o == $past(cnt_o) + CNT_ONE));
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (err_i && !clr_cnt_i && cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX));
    assert_capture_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_flag_i && !clr_cnt_i) |=> ($stable(loc_o) && $stable(syn_o)));
    assert_irq_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == '0) |-> !irq_o);
    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cnt_i && !err_i) |=> (cnt_o == '0 && !irq_o));
    assert_race_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cnt_i && err_i) |=> (cnt_o == CNT_ONE && irq_o));
endmodule

// File: rtl/ecc_rd_mux.sv
module ecc_rd_mux
    import ecc_log_pkg::*;
(
    input  logic [7:0]                 addr_i,
    input  logic [RANKS-1:0]           rank_en_i,
    input  logic [WORD_W-1:0]          ecc_cfg_i,
    input  logic [NCLS-1:0][CNT_W-1:0] cnt_i,
    input  dram_loc_t [NCLS-1:0]       loc_i,
    input  logic [NCLS-1:0][SYN_W-1:0] syn_i,
    output logic [WORD_W-1:0]          rdata_o
);
    logic [NCLS-1:0][WORD_W-1:0] cls_word;

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        localparam logic [7:0] BASE = (c == 0) ? OFS_CE_A0 : OFS_UE_A0;
        always_comb begin
            cls_word[c] = '0;
            if (addr_i == BASE)              cls_word[c] = loc_word0(loc_i[c]);
            if (addr_i == BASE + 8'h04)      cls_word[c] = loc_word1(loc_i[c]);
            for (int w = 0; w < SYN_WORDS; w++) begin
                if (addr_i == BASE + OFS_SYN_D + 8'(4 * w))
                    cls_word[c] = syn_i[c][w*WORD_W +: WORD_W];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int c = 0; c < NCLS; c++) rdata_o = rdata_o | cls_word[c];
        if (addr_i == OFS_CFG) rdata_o = {4'b0, rank_en_i, 24'b0};
        if (addr_i == OFS_ECC) rdata_o = ecc_cfg_i;
        if (addr_i == OFS_CNT) rdata_o = {cnt_i[1], cnt_i[0]};
    end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecc_log_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce_err,
    input  logic [1:0]   ce_rank,
    input  logic [1:0]   ce_bg,
    input  logic [2:0]   ce_bank,
    input  logic [17:0]  ce_row,
    input  logic [11:0]  ce_col,
    input  logic [95:0]  ce_syn,
    input  logic         ue_err,
    input  logic [1:0]   ue_rank,
    input  logic [1:0]   ue_bg,
    input  logic [2:0]   ue_bank,
    input  logic [17:0]  ue_row,
    input  logic [11:0]  ue_col,
    input  logic [95:0]  ue_syn,
    input  logic [3:0]   cfg_rank_en,
    input  logic [7:0]   reg_addr,
    input  logic         reg_wr,
    input  logic [31:0]  reg_wdata,
    output logic [31:0]  reg_rdata,
    output logic         irq_ce,
    output logic         irq_ue
);
    typedef struct packed {
        logic [WORD_W-1:0] ecc_cfg;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NCLS-1:0]             err;
    dram_loc_t [NCLS-1:0]        loc_in;
    logic [NCLS-1:0][SYN_W-1:0]  syn_in;
    logic [NCLS-1:0]             clr_flag, clr_cnt, irq;
    logic [NCLS-1:0][CNT_W-1:0]  cnt;
    dram_loc_t [NCLS-1:0]        loc_cap;
    logic [NCLS-1:0][SYN_W-1:0]  syn_cap;
    logic                        clr_wr;

    assign err    = {ue_err, ce_err};
    assign loc_in = {{ue_rank, ue_bg, ue_bank, ue_row, ue_col},
                     {ce_rank, ce_bg, ce_bank, ce_row, ce_col}};
    assign syn_in = {ue_syn, ce_syn};
    assign clr_wr = reg_wr && (reg_addr == OFS_CLR);

    always_comb begin
        st_d = st_q;
        if (reg_wr && reg_addr == OFS_ECC) st_d.ecc_cfg = reg_wdata & ECC_WMASK;
        clr_flag = clr_wr ? reg_wdata[1:0] : '0;
        clr_cnt  = clr_wr ? reg_wdata[3:2] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar c = 0; c < NCLS; c++) begin : g_trk
        ecc_class_tracker #(.CNT_BITS(CNT_W)) u_trk (
            .clk        (clk),
            .rst_n      (rst_n),
            .err_i      (err[c]),
            .loc_i      (loc_in[c]),
            .syn_i      (syn_in[c]),
            .clr_flag_i (clr_flag[c]),
            .clr_cnt_i  (clr_cnt[c]),
            .cnt_o      (cnt[c]),
            .loc_o      (loc_cap[c]),
            .syn_o      (syn_cap[c]),
            .irq_o      (irq[c])
        );
    end

    ecc_rd_mux u_mux (
        .addr_i    (reg_addr),
        .rank_en_i (cfg_rank_en),
        .ecc_cfg_i (st_q.ecc_cfg),
        .cnt_i     (cnt),
        .loc_i     (loc_cap),
        .syn_i     (syn_cap),
        .rdata_o   (reg_rdata)
    );

    assign irq_ce = irq[0];
    assign irq_ue = irq[1];

    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == OFS_ECC) |=> $stable(st_q.ecc_cfg));
    assert_cfg_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ecc_cfg & ~ECC_WMASK) == '0);
    assert_class_apart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_err && !ue_err && !clr_wr) |=> $stable(cnt[1]));
endmodule

// File: tb/ecc_err_log_tb.sv
module ecc_err_log_tb;
    logic clk = 0, rst_n = 0;
    logic ce_err = 0, ue_err = 0;
    logic [1:0] ce_rank = 0, ce_bg = 0, ue_rank = 0, ue_bg = 0;
    logic [2:0] ce_bank = 0, ue_bank = 0;
    logic [17:0] ce_row = 0, ue_row = 0;
    logic [11:0] ce_col = 0, ue_col = 0;
    logic [95:0] ce_syn = 0, ue_syn = 0;
    logic [3:0] cfg_rank_en = 0;
    logic [7:0] reg_addr = 0;
    logic reg_wr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic irq_ce, irq_ue;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    ecc_err_log u_dut (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    // error coordinates derived from a seed k
    function automatic logic [31:0] w0(int k);
        return {6'b0, 2'(k), 6'b0, 18'h2A5A5 ^ 18'(k)};
    endfunction
    function automatic logic [31:0] w1(int k);
        return {6'b0, 2'(k >> 2), 5'b0, 3'(k >> 4), 4'b0, 12'hC3C ^ 12'(k)};
    endfunction
    function automatic logic [95:0] sy(int k);
        return {32'hC000_0000 | 32'(k), 32'hB000_0000 | 32'(k), 32'hA000_0000 | 32'(k)};
    endfunction

    // set class inputs (cls 0 corrected, 1 uncorrectable), no clock advance
    task automatic set_err(input int cls, input int k);
        if (cls == 0) begin
            ce_err = 1; ce_rank = 2'(k); ce_bg = 2'(k >> 2); ce_bank = 3'(k >> 4);
            ce_row = 18'h2A5A5 ^ 18'(k); ce_col = 12'hC3C ^ 12'(k); ce_syn = sy(k);
        end else begin
            ue_err = 1; ue_rank = 2'(k); ue_bg = 2'(k >> 2); ue_bank = 3'(k >> 4);
            ue_row = 18'h2A5A5 ^ 18'(k); ue_col = 12'hC3C ^ 12'(k); ue_syn = sy(k);
        end
    endtask

    task automatic pulse(input int cls, input int k);
        @(negedge clk);
        set_err(cls, k);
        @(negedge clk);
        ce_err = 0; ue_err = 0;
    endtask

    task automatic clr_with_err(input logic [3:0] m, input int k);
        @(negedge clk);
        reg_addr = 8'h7C; reg_wdata = {28'b0, m}; reg_wr = 1;
        set_err(0, k);
        @(negedge clk);
        reg_wr = 0; ce_err = 0;
    endtask

    task automatic cap_chk(input string tag, input int cls, input int k);
        logic [7:0] b;
        logic [95:0] s;
        b = (cls == 0) ? 8'h84 : 8'hA4;
        s = sy(k);
        rdchk(tag, b, w0(k));
        rdchk(tag, b + 8'h04, w1(k));
        rdchk(tag, b + 8'h08, s[31:0]);
        rdchk(tag, b + 8'h0C, s[63:32]);
        rdchk(tag, b + 8'h10, s[95:64]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] pats [4];
        pats = '{32'hFFFF_FFFF, 32'h0, 32'h0000_0015, 32'h0000_000A};
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R9 reset state
        rdchk("R9 count", 8'h80, 0);
        rdchk("R9 ecc cfg", 8'h70, 0);
        rdchk("R9 ce addr", 8'h84, 0);
        rdchk("R9 ue syn", 8'hB4, 0);
        chk("R9 irqs", {30'b0, irq_ue, irq_ce}, 0);

        // R7 rank mask sweep
        for (int m = 0; m < 16; m++) begin
            cfg_rank_en = 4'(m);
            rdchk("R7 rank mask", 8'h00, {4'b0, 4'(m), 24'b0});
        end
        wr(8'h00, 32'hFFFF_FFFF);
        rdchk("R10 cfg word write ignored", 8'h00, {4'b0, cfg_rank_en, 24'b0});

        // R8 settings register
        foreach (pats[i]) begin
            wr(8'h70, pats[i]);
            rdchk("R8 ecc cfg", 8'h70, pats[i] & 32'h17);
        end

        // R1 R3 R4 R11 basic capture
        pulse(0, 5);
        rdchk("R1 ce count", 8'h80, 32'h0000_0001);
        cap_chk("R3 ce first capture", 0, 5);
        chk("R4 irq ce set", irq_ce, 1);
        chk("R11 irq ue quiet", irq_ue, 0);
        rdchk("R11 ue capture untouched", 8'hA4, 0);
        pulse(0, 9);
        rdchk("R1 ce count 2", 8'h80, 32'h0000_0002);
        cap_chk("R3 ce capture held", 0, 5);
        pulse(1, 21);
        rdchk("R1 both counts", 8'h80, 32'h0001_0002);
        cap_chk("R3 ue capture", 1, 21);
        cap_chk("R11 ce capture kept", 0, 5);
        chk("R4 irq ue set", irq_ue, 1);

        // R10 writes to read-only words
        wr(8'h80, 32'hFFFF_FFFF);
        wr(8'h84, 32'h0);
        rdchk("R10 count write ignored", 8'h80, 32'h0001_0002);
        rdchk("R10 capture write ignored", 8'h84, w0(5));

        // R5 clear sweep
        for (int m = 0; m < 16; m++) begin
            wr(8'h7C, 32'hF);
            pulse(0, m); pulse(0, m + 1);
            pulse(1, m + 2); pulse(1, m + 3); pulse(1, m + 4);
            wr(8'h7C, 32'(m));
            rdchk("R5 counts after clear", 8'h80,
                  {(m & 8) ? 16'd0 : 16'd3, (m & 4) ? 16'd0 : 16'd2});
            chk("R5 R4 irq ce", irq_ce, ((m & 1) == 0) && ((m & 4) == 0));
            chk("R5 R4 irq ue", irq_ue, ((m & 2) == 0) && ((m & 8) == 0));
            rdchk("R5 clear reads zero", 8'h7C, 0);
        end
        wr(8'h7C, 32'hF);
        pulse(0, 40);
        cap_chk("R3 new capture after clear", 0, 40);

        // R6 races between clear and error
        wr(8'h7C, 32'hF);
        pulse(0, 1); pulse(0, 2);
        clr_with_err(4'h5, 3);
        rdchk("R6 count clear loses", 8'h80, 1);
        cap_chk("R6 flag clear loses", 0, 3);
        chk("R6 irq stays", irq_ce, 1);
        clr_with_err(4'h1, 4);
        rdchk("R6 flag-only race count", 8'h80, 2);
        cap_chk("R6 flag-only race capture", 0, 4);
        clr_with_err(4'h4, 6);
        rdchk("R6 count-only race count", 8'h80, 1);
        cap_chk("R6 count-only race keeps capture", 0, 4);

        // R2 saturation
        wr(8'h7C, 32'hF);
        @(negedge clk);
        set_err(0, 7);
        repeat (65540) @(negedge clk);
        ce_err = 0;
        rdchk("R2 saturated", 8'h80, 32'h0000_FFFF);
        pulse(0, 8);
        rdchk("R2 stays saturated", 8'h80, 32'h0000_FFFF);
        chk("R2 irq at saturation", irq_ce, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule